// File: doc/BRIEF.md
# Serial Packet Framer with Selectable Bit Order

The framer gathers one header byte, four converter samples and one ECC byte into a fixed 64-bit packet and sends it out one bit per clock. The clock runs at sixteen times the sample rate, so each packet carries exactly the four samples that arrive during its own four sample periods. The ECC byte is computed elsewhere and arrives as an input. The block does no line coding.

Two controls shape the stream. The first chooses whether every field goes out most-significant bit first or least-significant bit first. The second complements every transmitted bit. The field order (header, sample 0 to sample 3, ECC) never changes. The two controls act independently of each other.

Contents and controls are taken only at a packet boundary, so the upstream logic may change them freely while a packet is in flight. With `tx_en` held high, packets follow each other with no gap. Each packet is marked by a one-cycle start pulse on its first bit.

Top module: `pkt_framer`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `ser_valid`, `ser_sop` and `ser_data` are all 0.
- R2: A packet is 64 consecutive valid bits in a fixed field order: `hdr_in` (8 bits), then sample 0 to sample 3 (sample j is `smp_in[12*j +: 12]`), then `ecc_in` (8 bits).
- R3: With `lsb_first`=0, each field is sent most-significant bit first.
- R4: With `lsb_first`=1, the bits within each field (header, each sample, ECC) are sent in reverse order, while the field order stays as in R2.
- R5: With `invert`=1, every transmitted bit is complemented. This applies equally under either bit order, and the inversion does not change which bit is sent in which slot.
- R6: `ser_sop` is 1 on the first bit of every packet and 0 on every other cycle.
- R7: Packet contents, `lsb_first` and `invert` are captured only at a boundary, meaning a cycle when the line is idle or when it carries the last bit of a packet. Changes on these inputs during a packet have no effect on that packet.
- R8: If `tx_en` is 0 at a boundary, the stream stops after the last bit. While idle, `ser_valid`, `ser_sop` and `ser_data` are 0.
- R9: If `tx_en` is held at 1, packets follow each other with no idle cycle. That gives 16 bits per sample period.
- R10: If `tx_en` is 1 while the line is idle, the first bit of a packet appears on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock, 16 times the sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_en | input | 1 | Request to send a packet at the next boundary |
| lsb_first | input | 1 | 1: reverse the bit order within each field |
| invert | input | 1 | 1: complement every transmitted bit |
| hdr_in | input | 8 | Header byte |
| smp_in | input | 48 | Four 12-bit samples, sample j at bits 12*j+11..12*j |
| ecc_in | input | 8 | Error-correction byte |
| ser_data | output | 1 | Serial data |
| ser_valid | output | 1 | High on every cycle that carries a packet bit |
| ser_sop | output | 1 | High on the first bit of each packet |

## Verification
The bench builds the framer with its default widths: an 8-bit header, four 12-bit samples and an 8-bit ECC byte. This gives a 64-bit packet and a 6-bit bit counter that wraps from 63 to 0 exactly at the packet boundary.

These values bring within reach:
- back-to-back packets that cross that wrap;
- a stop decided on bit 63;
- reversal of fields of two different lengths (8 and 12 bits), all four combinations of order and inversion, and input changes placed on the first bit of a packet.

// File: rtl/pf_pkg.sv
package pf_pkg;
    localparam int HDR_W_DEF = 8;
    localparam int SMP_W_DEF = 12;
    localparam int N_SMP_DEF = 4;
    localparam int ECC_W_DEF = 8;

    typedef enum logic {
        ORDER_MSB = 1'b0,
        ORDER_LSB = 1'b1
    } bit_order_e;
endpackage

// File: rtl/pf_field_order.sv
module pf_field_order #(
    parameter int W = 8
) (
    input  logic [W-1:0] fld_in,
    input  logic         lsb_sel,
    output logic [W-1:0] fld_out
);
    logic [W-1:0] rev;

    // Mirror the field so that its LSB lands in the first-sent (top) slot.
    for (genvar k = 0; k < W; k++) begin : g_rev
        assign rev[k] = fld_in[W-1-k];
    end

    assign fld_out = lsb_sel ? rev : fld_in;
endmodule

// File: rtl/pf_assemble.sv
module pf_assemble #(
    parameter int HDR_W = pf_pkg::HDR_W_DEF,
    parameter int SMP_W = pf_pkg::SMP_W_DEF,
    parameter int N_SMP = pf_pkg::N_SMP_DEF,
    parameter int ECC_W = pf_pkg::ECC_W_DEF,
    localparam int DAT_W = SMP_W * N_SMP,
    localparam int PKT_W = HDR_W + DAT_W + ECC_W
) (
    input  logic [HDR_W-1:0] hdr,
    input  logic [DAT_W-1:0] smp,
    input  logic [ECC_W-1:0] ecc,
    input  pf_pkg::bit_order_e order,
    output logic [PKT_W-1:0] pkt
);
    logic sel;
    assign sel = (order == pf_pkg::ORDER_LSB);

    logic [HDR_W-1:0] hdr_o;
    logic [DAT_W-1:0] dat_o;
    logic [ECC_W-1:0] ecc_o;

    pf_field_order #(.W(HDR_W)) u_hdr (.fld_in(hdr), .lsb_sel(sel), .fld_out(hdr_o));
    pf_field_order #(.W(ECC_W)) u_ecc (.fld_in(ecc), .lsb_sel(sel), .fld_out(ecc_o));

    // Sample 0 is sent first, so it takes the highest slot of the data field.
    for (genvar j = 0; j < N_SMP; j++) begin : g_smp
        pf_field_order #(.W(SMP_W)) u_smp (
            .fld_in (smp[j*SMP_W +: SMP_W]),
            .lsb_sel(sel),
            .fld_out(dat_o[(N_SMP-1-j)*SMP_W +: SMP_W])
        );
    end

    // Bit PKT_W-1 goes out first.
    assign pkt = {hdr_o, dat_o, ecc_o};
endmodule

// File: rtl/pf_shifter.sv
module pf_shifter #(
    parameter int PKT_W = 64,
    localparam int CNT_W = $clog2(PKT_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             invert,
    input  logic [PKT_W-1:0] pkt,
    output logic             ser_data,
    output logic             ser_valid,
    output logic             ser_sop
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

    typedef struct packed {
        logic             busy;
        logic             inv;
        logic [CNT_W-1:0] cnt;
        logic [PKT_W-1:0] sh;
    } sh_state_t;

    sh_state_t st_d, st_q;
    logic      boundary;

    assign boundary = !st_q.busy || (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (boundary && tx_en) begin
            st_d.busy = 1'b1;
            st_d.inv  = invert;
            st_d.cnt  = '0;
            st_d.sh   = pkt;
        end else if (st_q.busy) begin
            st_d.sh  = {st_q.sh[PKT_W-2:0], 1'b0};
            st_d.cnt = st_q.cnt + 1'b1;
            if (boundary) begin
                st_d.busy = 1'b0;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ser_valid = st_q.busy;
    assign ser_sop   = st_q.busy && (st_q.cnt == '0);
    assign ser_data  = st_q.busy && (st_q.sh[PKT_W-1] ^ st_q.inv);
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer #(
    parameter int HDR_W = pf_pkg::HDR_W_DEF,
    parameter int SMP_W = pf_pkg::SMP_W_DEF,
    parameter int N_SMP = pf_pkg::N_SMP_DEF,
    parameter int ECC_W = pf_pkg::ECC_W_DEF,
    localparam int DAT_W = SMP_W * N_SMP,
    localparam int PKT_W = HDR_W + DAT_W + ECC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             lsb_first,
    input  logic             invert,
    input  logic [HDR_W-1:0] hdr_in,
    input  logic [DAT_W-1:0] smp_in,
    input  logic [ECC_W-1:0] ecc_in,
    output logic             ser_data,
    output logic             ser_valid,
    output logic             ser_sop
);
    logic [PKT_W-1:0]   pkt;
    pf_pkg::bit_order_e order;

    assign order = lsb_first ? pf_pkg::ORDER_LSB : pf_pkg::ORDER_MSB;

    pf_assemble #(
        .HDR_W(HDR_W), .SMP_W(SMP_W), .N_SMP(N_SMP), .ECC_W(ECC_W)
    ) u_asm (
        .hdr(hdr_in), .smp(smp_in), .ecc(ecc_in), .order(order), .pkt(pkt)
    );

    pf_shifter #(.PKT_W(PKT_W)) u_sh (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .invert(invert), .pkt(pkt),
        .ser_data(ser_data), .ser_valid(ser_valid), .ser_sop(ser_sop)
    );
endmodule

// File: rtl/pkt_framer_checker.sv
module pkt_framer_checker #(
    parameter int PKT_W = 64,
    localparam int CNT_W = $clog2(PKT_W)
) (
    input logic clk,
    input logic rst_n,
    input logic tx_en,
    input logic ser_data,
    input logic ser_valid,
    input logic ser_sop
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

    logic [CNT_W-1:0] bit_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         bit_cnt <= '0;
        else if (ser_valid) bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
        else                bit_cnt <= '0;
    end

    assert_sop_first_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |-> (ser_sop == (bit_cnt == '0)));

    assert_sop_needs_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sop |-> ser_valid);

    assert_stop_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_valid) |-> ($past(bit_cnt) == LAST));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_valid |-> (!ser_data && !ser_sop));

    assert_start_marked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_valid) |-> ser_sop);

    assert_start_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_valid && tx_en) |=> ser_valid);

    assert_no_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_valid && bit_cnt == LAST && tx_en) |=> (ser_valid && ser_sop));
endmodule

bind pkt_framer pkt_framer_checker #(.PKT_W(PKT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ser_data(ser_data),
    .ser_valid(ser_valid), .ser_sop(ser_sop)
);

// File: tb/pkt_framer_bench.sv
module pkt_framer_bench;
    localparam int NV = 6;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        tx_en, lsb_first, invert;
    logic [7:0]  hdr_in, ecc_in;
    logic [47:0] smp_in;
    logic        ser_data, ser_valid, ser_sop;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    pkt_framer u_pkt_framer (
        .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .lsb_first(lsb_first), .invert(invert),
        .hdr_in(hdr_in), .smp_in(smp_in), .ecc_in(ecc_in),
        .ser_data(ser_data), .ser_valid(ser_valid), .ser_sop(ser_sop)
    );

    // Vector fields: {lsb_first, invert, hdr, samples, ecc}.
    localparam logic [65:0] VEC [NV] = '{
        {1'b0, 1'b0, 8'hA5, 48'h123_456_789_ABC, 8'h3C},
        {1'b1, 1'b0, 8'hA5, 48'h123_456_789_ABC, 8'h3C},
        {1'b0, 1'b1, 8'h81, 48'hF00_0F0_00F_801, 8'hE7},
        {1'b1, 1'b1, 8'h01, 48'h800_001_C00_003, 8'h80},
        {1'b0, 1'b0, 8'hFF, 48'h000_FFF_000_FFF, 8'h00},
        {1'b1, 1'b0, 8'h6D, 48'h5A5_A5A_3C3_C3C, 8'hB2}
    };

    function automatic logic [63:0] model(input logic [65:0] v);
        logic [63:0] o;
        logic        lsb, inv;
        int          pos;
        lsb = v[65];
        inv = v[64];
        pos = 63;
        for (int k = 0; k < 8; k++) begin
            o[pos] = (lsb ? v[56 + k] : v[63 - k]) ^ inv;
            pos--;
        end
        for (int j = 0; j < 4; j++) begin
            for (int k = 0; k < 12; k++) begin
                o[pos] = (lsb ? v[8 + 12*j + k] : v[8 + 12*j + 11 - k]) ^ inv;
                pos--;
            end
        end
        for (int k = 0; k < 8; k++) begin
            o[pos] = (lsb ? v[k] : v[7 - k]) ^ inv;
            pos--;
        end
        return o;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_vec(input logic [65:0] v);
        {lsb_first, invert, hdr_in, smp_in, ecc_in} = v;
    endtask

    task automatic drive_junk();
        lsb_first = ~lsb_first;
        invert    = ~invert;
        hdr_in    = 8'($urandom);
        smp_in    = {16'($urandom), 32'($urandom)};
        ecc_in    = 8'($urandom);
    endtask

    initial begin
        #200000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [63:0] cap;
        int          sop_cnt, val_cnt, idle_bad;

        rst_n = 1'b0;
        tx_en = 1'b1;
        drive_vec(VEC[0]);
        repeat (3) @(negedge clk);
        // R1: tx_en is high during reset, yet the outputs stay quiet.
        check("R1 reset", {61'd0, ser_valid, ser_sop, ser_data}, 64'd0);
        tx_en = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {61'd0, ser_valid, ser_sop, ser_data}, 64'd0);

        // Vector table: packets sent back to back, junk driven mid-packet.
        drive_vec(VEC[0]);
        tx_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            sop_cnt = 0;
            val_cnt = 0;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                cap[63 - i] = ser_data;
                if (ser_sop) sop_cnt += (i == 0) ? 1 : 100;
                if (ser_valid) val_cnt++;
                if (i == 0) drive_junk();  // R7: no effect on this packet
                if (i == 62) begin
                    if (v + 1 < NV) drive_vec(VEC[v + 1]);
                    else tx_en = 1'b0;
                end
            end
            check("R2/R3/R4/R5/R7 packet", cap, model(VEC[v]));
            check("R6 sop once on first bit", 64'(sop_cnt), 64'd1);
            check("R9 contiguous valid", 64'(val_cnt), 64'd64);
        end

        // R8: the stream stops after the last bit and the line stays quiet.
        idle_bad = 0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            if (ser_valid || ser_sop || ser_data) idle_bad++;
            drive_junk();
        end
        check("R8 idle after stop", 64'(idle_bad), 64'd0);

        // R10: one cycle of tx_en while idle starts a packet on the next cycle.
        drive_vec(VEC[3]);
        tx_en = 1'b1;
        @(negedge clk);
        tx_en = 1'b0;
        check("R10 start latency", {62'd0, ser_valid, ser_sop}, 64'd3);
        cap[63] = ser_data;
        drive_junk();
        for (int i = 1; i < 64; i++) begin
            @(negedge clk);
            cap[63 - i] = ser_data;
        end
        check("R4/R5 single packet", cap, model(VEC[3]));
        @(negedge clk);
        check("R8 single packet stops", {62'd0, ser_valid, ser_sop}, 64'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule